// File: doc/BRIEF.md
# Twin predicate step skipper

This block walks two element indices, one for the source side and one for the destination side, across a vector of up to `MAX_VL` elements. Each index moves only to elements whose bit is set in its own predicate. Every matched position produces one (source step, destination step) pair. A stream of such pairs acts as a gather on the read side followed by a scatter on the write side. The surrounding issue logic takes one pair per handshake and performs the register reads and writes for it. Operand fetch and execution are not part of this block.

A run starts with a single-cycle `start_i` while the block is idle. On that edge the block captures the vector length, the predicates and the options. For each side, the predicate can come from an integer-register bitmask or from per-element condition-register field bits. In single mode, both sides use the source predicate. Zeroing is enabled per side. With zeroing on, a masked-out element is not skipped. It is emitted with a flag, so the source operand or the destination write becomes zero. Every pair also carries the index of the condition field that belongs to the destination element. The zero-result test for that element updates that field, not one fixed field.

Top module: `pred_step_skip`

## Requirements
- R1: After reset, `busy_o`, `pair_valid_o` and `done_o` are 0.
- R2: `start_i` is sampled only while `busy_o` is 0. A `start_i` during a walk changes nothing in that walk.
- R3: Without source zeroing, the source steps are exactly the source-predicate set positions below VL, in ascending order, and `src_zero_o` is 0 on each.
- R4: Without destination zeroing, the destination steps are exactly the destination-predicate set positions below VL, in ascending order, and `dst_zero_o` is 0 on each.
- R5: An all-ones predicate takes every element 0..VL-1 through the same advancing logic.
- R6: When `twin_i` is 0, the destination side uses the source predicate and its source select, and the destination predicate inputs are ignored.
- R7: For each side, a select bit of 0 takes the integer mask and a select bit of 1 takes the condition-field bit mask. Bit i of a mask belongs to element i.
- R8: With source zeroing, every source element below VL is visited. `src_zero_o` is 1 exactly on the elements whose source predicate bit is 0.
- R9: With destination zeroing, every destination element below VL is visited. `dst_zero_o` is 1 exactly on the elements whose destination predicate bit is 0.
- R10: The walk ends as soon as either side has no remaining element below VL. `done_o` is then high for exactly one cycle with `pair_valid_o` low, and the block returns to idle. No pair ever carries a step at or above VL. A VL of 0 yields no pairs.
- R11: While `pair_valid_o` is high and `pair_ready_i` is low, the pair and its flags hold. Both indices advance only on a handshake.
- R12: `cr_field_o` equals (`cr_base_i` captured at start + `dst_step_o`) modulo `CR_FIELDS`.
- R13: A VL above `MAX_VL` is treated as `MAX_VL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (sampled when idle) |
| vl_i | input | $clog2(MAX_VL+1) | Vector length |
| twin_i | input | 1 | 1 = separate destination predicate, 0 = single predicate |
| src_from_cr_i | input | 1 | Source predicate select (0 integer, 1 condition bits) |
| dst_from_cr_i | input | 1 | Destination predicate select (0 integer, 1 condition bits) |
| src_int_mask_i | input | MAX_VL | Source integer-register mask |
| src_cr_mask_i | input | MAX_VL | Source condition-field bits |
| dst_int_mask_i | input | MAX_VL | Destination integer-register mask |
| dst_cr_mask_i | input | MAX_VL | Destination condition-field bits |
| src_zero_i | input | 1 | Source zeroing enable |
| dst_zero_i | input | 1 | Destination zeroing enable |
| cr_base_i | input | $clog2(CR_FIELDS) | First condition field of the vector |
| busy_o | output | 1 | Walk in progress |
| pair_valid_o | output | 1 | Pair available |
| pair_ready_i | input | 1 | Consumer takes the pair |
| src_step_o | output | $clog2(MAX_VL+1) | Source element index |
| dst_step_o | output | $clog2(MAX_VL+1) | Destination element index |
| src_zero_o | output | 1 | Source operand is to be zero |
| dst_zero_o | output | 1 | Destination is written as zero |
| cr_field_o | output | $clog2(CR_FIELDS) | Condition field for this element's result test |
| done_o | output | 1 | One-cycle end-of-walk pulse |

## Verification
A handshake that consumes the last available pair coincides with the end-of-walk decision. On the next cycle, the same lookahead must either present a new pair or raise `done_o`, and never both. The bench provokes this with uneven predicates: one side runs out while the other still has set bits. It does so under always-ready, alternating and pseudo-random ready patterns. A start request also arrives mid-walk, at the same time as a handshake. Each cycle is judged against a behavioural model that precomputes the pair list and tracks how many pairs have been consumed.

// File: rtl/psk_pkg.sv
package psk_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } psk_state_e;
endpackage

// File: rtl/psk_mask_sel.sv
module psk_mask_sel #(
  parameter int N = 16
) (
  input  logic [N-1:0] int_mask_i,
  input  logic [N-1:0] cr_mask_i,
  input  logic         from_cr_i,
  input  logic         zero_i,
  output logic [N-1:0] pred_o,
  output logic [N-1:0] walk_o
);
  assign pred_o = from_cr_i ? cr_mask_i : int_mask_i;
  // zeroing visits every element; the predicate then only flags zero
  assign walk_o = zero_i ? {N{1'b1}} : pred_o;
endmodule

// File: rtl/psk_find_next.sv
module psk_find_next #(
  parameter int N  = 16,
  parameter int IW = 5
) (
  input  logic [N-1:0]  mask_i,
  input  logic [IW-1:0] from_i,
  input  logic [IW-1:0] vl_i,
  output logic          found_o,
  output logic [IW-1:0] pos_o
);
  always_comb begin
    found_o = 1'b0;
    pos_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i] && (IW'(i) >= from_i) && (IW'(i) < vl_i)) begin
        found_o = 1'b1;
        pos_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pred_step_skip.sv
module pred_step_skip
  import psk_pkg::*;
#(
  parameter int MAX_VL    = 16,
  parameter int CR_FIELDS = 128,
  localparam int IW = $clog2(MAX_VL + 1),
  localparam int PW = $clog2(MAX_VL),
  localparam int CW = $clog2(CR_FIELDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IW-1:0]     vl_i,
  input  logic              twin_i,
  input  logic              src_from_cr_i,
  input  logic              dst_from_cr_i,
  input  logic [MAX_VL-1:0] src_int_mask_i,
  input  logic [MAX_VL-1:0] src_cr_mask_i,
  input  logic [MAX_VL-1:0] dst_int_mask_i,
  input  logic [MAX_VL-1:0] dst_cr_mask_i,
  input  logic              src_zero_i,
  input  logic              dst_zero_i,
  input  logic [CW-1:0]     cr_base_i,
  output logic              busy_o,
  output logic              pair_valid_o,
  input  logic              pair_ready_i,
  output logic [IW-1:0]     src_step_o,
  output logic [IW-1:0]     dst_step_o,
  output logic              src_zero_o,
  output logic              dst_zero_o,
  output logic [CW-1:0]     cr_field_o,
  output logic              done_o
);
  localparam logic [IW-1:0] VL_MAX = IW'(MAX_VL);

  psk_state_e        state_q;
  logic [IW-1:0]     vl_q, src_idx_q, dst_idx_q;
  logic [MAX_VL-1:0] src_pred_q, dst_pred_q, src_walk_q, dst_walk_q;
  logic [CW-1:0]     base_q;

  // single mode: destination follows the source predicate choice
  logic [MAX_VL-1:0] dst_int_sel, dst_cr_sel;
  logic              dst_from_sel;
  assign dst_int_sel  = twin_i ? dst_int_mask_i : src_int_mask_i;
  assign dst_cr_sel   = twin_i ? dst_cr_mask_i  : src_cr_mask_i;
  assign dst_from_sel = twin_i ? dst_from_cr_i  : src_from_cr_i;

  logic [MAX_VL-1:0] src_pred_d, src_walk_d, dst_pred_d, dst_walk_d;

  psk_mask_sel #(.N(MAX_VL)) u_src_sel (
    .int_mask_i (src_int_mask_i),
    .cr_mask_i  (src_cr_mask_i),
    .from_cr_i  (src_from_cr_i),
    .zero_i     (src_zero_i),
    .pred_o     (src_pred_d),
    .walk_o     (src_walk_d)
  );

  psk_mask_sel #(.N(MAX_VL)) u_dst_sel (
    .int_mask_i (dst_int_sel),
    .cr_mask_i  (dst_cr_sel),
    .from_cr_i  (dst_from_sel),
    .zero_i     (dst_zero_i),
    .pred_o     (dst_pred_d),
    .walk_o     (dst_walk_d)
  );

  logic          src_found, dst_found;
  logic [IW-1:0] src_pos, dst_pos;

  psk_find_next #(.N(MAX_VL), .IW(IW)) u_src_next (
    .mask_i  (src_walk_q),
    .from_i  (src_idx_q),
    .vl_i    (vl_q),
    .found_o (src_found),
    .pos_o   (src_pos)
  );

  psk_find_next #(.N(MAX_VL), .IW(IW)) u_dst_next (
    .mask_i  (dst_walk_q),
    .from_i  (dst_idx_q),
    .vl_i    (vl_q),
    .found_o (dst_found),
    .pos_o   (dst_pos)
  );

  logic walking, both_found, take;
  assign walking    = (state_q == ST_WALK);
  assign both_found = src_found && dst_found;
  assign take       = walking && both_found && pair_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      vl_q       <= '0;
      src_idx_q  <= '0;
      dst_idx_q  <= '0;
      src_pred_q <= '0;
      dst_pred_q <= '0;
      src_walk_q <= '0;
      dst_walk_q <= '0;
      base_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q    <= ST_WALK;
            vl_q       <= (vl_i > VL_MAX) ? VL_MAX : vl_i;
            src_idx_q  <= '0;
            dst_idx_q  <= '0;
            src_pred_q <= src_pred_d;
            dst_pred_q <= dst_pred_d;
            src_walk_q <= src_walk_d;
            dst_walk_q <= dst_walk_d;
            base_q     <= cr_base_i;
          end
        end
        ST_WALK: begin
          if (!both_found) begin
            state_q <= ST_IDLE;
          end else if (take) begin
            src_idx_q <= src_pos + IW'(1);
            dst_idx_q <= dst_pos + IW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = walking;
  assign pair_valid_o = walking && both_found;
  assign done_o       = walking && !both_found;
  assign src_step_o   = src_pos;
  assign dst_step_o   = dst_pos;
  assign src_zero_o   = pair_valid_o && !src_pred_q[src_pos[PW-1:0]];
  assign dst_zero_o   = pair_valid_o && !dst_pred_q[dst_pos[PW-1:0]];
  assign cr_field_o   = base_q + CW'(dst_pos);

endmodule

// File: rtl/psk_checker.sv
module psk_checker #(
  parameter int MAX_VL    = 16,
  parameter int CR_FIELDS = 128,
  localparam int IW = $clog2(MAX_VL + 1),
  localparam int CW = $clog2(CR_FIELDS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [IW-1:0] vl_i,
  input logic [CW-1:0] cr_base_i,
  input logic          busy_o,
  input logic          pair_valid_o,
  input logic          pair_ready_i,
  input logic [IW-1:0] src_step_o,
  input logic [IW-1:0] dst_step_o,
  input logic [CW-1:0] cr_field_o,
  input logic          done_o
);
  logic [IW-1:0] vl_c;
  logic [CW-1:0] base_c;
  logic [CW-1:0] want_field;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_c   <= '0;
      base_c <= '0;
    end else if (start_i && !busy_o) begin
      vl_c   <= (vl_i > IW'(MAX_VL)) ? IW'(MAX_VL) : vl_i;
      base_c <= cr_base_i;
    end
  end

  assign want_field = base_c + CW'(dst_step_o);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!pair_valid_o && !done_o));

  p_step_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && pair_ready_i) |=>
      (!pair_valid_o || ((src_step_o > $past(src_step_o)) && (dst_step_o > $past(dst_step_o)))));

  p_bound_vl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |-> ((src_step_o < vl_c) && (dst_step_o < vl_c)));

  p_done_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pair_valid_o && done_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  p_hold_pair_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && !pair_ready_i) |=>
      (pair_valid_o && $stable(src_step_o) && $stable(dst_step_o) && $stable(cr_field_o)));

  p_own_field_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |-> (cr_field_o == want_field));

endmodule

bind pred_step_skip psk_checker #(.MAX_VL(MAX_VL), .CR_FIELDS(CR_FIELDS)) u_psk_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .vl_i         (vl_i),
  .cr_base_i    (cr_base_i),
  .busy_o       (busy_o),
  .pair_valid_o (pair_valid_o),
  .pair_ready_i (pair_ready_i),
  .src_step_o   (src_step_o),
  .dst_step_o   (dst_step_o),
  .cr_field_o   (cr_field_o),
  .done_o       (done_o)
);

// File: tb/pred_step_skip_bench.sv
`timescale 1ns/1ps
module pred_step_skip_bench;
  localparam int N  = 16;
  localparam int IW = $clog2(N + 1);
  localparam int CF = 128;
  localparam int CW = $clog2(CF);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [IW-1:0] vl_i = '0;
  logic twin_i = 1'b1;
  logic src_from_cr_i = 1'b0, dst_from_cr_i = 1'b0;
  logic [N-1:0] src_int_mask_i = '0, src_cr_mask_i = '0, dst_int_mask_i = '0, dst_cr_mask_i = '0;
  logic src_zero_i = 1'b0, dst_zero_i = 1'b0;
  logic [CW-1:0] cr_base_i = '0;
  logic busy_o, pair_valid_o, src_zero_o, dst_zero_o, done_o;
  logic pair_ready_i = 1'b0;
  logic [IW-1:0] src_step_o, dst_step_o;
  logic [CW-1:0] cr_field_o;

  always #2.5 clk_i = ~clk_i;

  pred_step_skip #(.MAX_VL(N), .CR_FIELDS(CF)) u_pred_step_skip (.*);

  int checks = 0, failures = 0;
  bit finished = 0;
  int m_busy = 0, m_k = 0, m_n = 0, m_base = 0;
  int e_src[N], e_dst[N];
  bit e_sz[N], e_dz[N];
  int cyc_n = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic build();
    int vlc, ns, nd;
    bit sm, dm;
    vlc = (int'(vl_i) > N) ? N : int'(vl_i);
    ns = 0; nd = 0;
    for (int i = 0; i < vlc; i++) begin
      sm = src_from_cr_i ? src_cr_mask_i[i] : src_int_mask_i[i];
      if (twin_i) dm = dst_from_cr_i ? dst_cr_mask_i[i] : dst_int_mask_i[i];
      else        dm = sm;
      if (sm || src_zero_i) begin e_src[ns] = i; e_sz[ns] = !sm; ns++; end
      if (dm || dst_zero_i) begin e_dst[nd] = i; e_dz[nd] = !dm; nd++; end
    end
    m_n = (ns < nd) ? ns : nd;
    m_k = 0;
    m_base = int'(cr_base_i);
  endtask

  // called just after a falling edge: check, drive, advance model
  task automatic cyc(input bit st, input int rmode);
    bit rdy;
    bit ev;
    ev = (m_busy != 0) && (m_k < m_n);
    chk("R1/R2 busy", int'(busy_o), m_busy);
    chk("R10 valid", int'(pair_valid_o), int'(ev));
    chk("R10 done", int'(done_o), int'((m_busy != 0) && (m_k >= m_n)));
    if (ev && pair_valid_o) begin
      chk("R3 src_step", int'(src_step_o), e_src[m_k]);
      chk("R4 dst_step", int'(dst_step_o), e_dst[m_k]);
      chk("R8 src_zero", int'(src_zero_o), int'(e_sz[m_k]));
      chk("R9 dst_zero", int'(dst_zero_o), int'(e_dz[m_k]));
      chk("R12 cr_field", int'(cr_field_o), (m_base + e_dst[m_k]) % CF);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rmode)
      0: rdy = 1'b1;
      1: rdy = cyc_n[0];
      default: rdy = lfsr[0];
    endcase
    cyc_n++;
    start_i = st;
    pair_ready_i = rdy;
    if (m_busy == 0) begin
      if (st) begin build(); m_busy = 1; end
    end else if (m_k < m_n) begin
      if (rdy) m_k++;
    end else begin
      m_busy = 0;
    end
    @(negedge clk_i);
  endtask

  task automatic drain(input int rmode);
    for (int g = 0; g < 200 && m_busy != 0; g++) cyc(0, rmode);
    cyc(0, rmode);
  endtask

  task automatic setup(input int vl, input bit tw, input bit sc, input bit dc,
                       input logic [N-1:0] si, input logic [N-1:0] scm,
                       input logic [N-1:0] di, input logic [N-1:0] dcm,
                       input bit sz, input bit dz, input int base);
    vl_i = IW'(vl); twin_i = tw; src_from_cr_i = sc; dst_from_cr_i = dc;
    src_int_mask_i = si; src_cr_mask_i = scm; dst_int_mask_i = di; dst_cr_mask_i = dcm;
    src_zero_i = sz; dst_zero_i = dz; cr_base_i = CW'(base);
  endtask

  task automatic run(input int rmode);
    cyc(1, rmode);
    drain(rmode);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 valid", int'(pair_valid_o), 0);
    chk("R1 done", int'(done_o), 0);
    // R5: all ones, every element
    setup(8, 1, 0, 0, 16'hFFFF, 16'h0, 16'hFFFF, 16'h0, 0, 0, 3);
    run(0);
    // R3 R4: independent skipping, alternating ready (R11 hold)
    setup(8, 1, 0, 0, 16'h00A6, 16'h0, 16'h0039, 16'h0, 0, 0, 10);
    run(1);
    run(2);
    // R6: single mode ignores destination predicate inputs
    setup(16, 0, 0, 1, 16'h5A5A, 16'h0, 16'hFFFF, 16'hFFFF, 0, 0, 0);
    run(2);
    // R7: condition-bit source vs integer destination
    setup(12, 1, 1, 0, 16'hFFFF, 16'h0C53, 16'h0F0F, 16'h0000, 0, 0, 20);
    run(0);
    setup(12, 1, 0, 1, 16'h0C53, 16'h0, 16'h0000, 16'h0EE1, 0, 0, 20);
    run(2);
    // R8: source zeroing
    setup(10, 1, 0, 0, 16'h0125, 16'h0, 16'h03FF, 16'h0, 1, 0, 0);
    run(1);
    // R9 R12: destination zeroing with field wrap
    setup(9, 1, 0, 0, 16'hFFFF, 16'h0, 16'h0112, 16'h0, 0, 1, 124);
    run(2);
    // R10: uneven counts, empty mask, zero length
    setup(16, 1, 0, 0, 16'h8100, 16'h0, 16'h1F00, 16'h0, 0, 0, 0);
    run(0);
    setup(16, 1, 0, 0, 16'h0000, 16'h0, 16'hFFFF, 16'h0, 0, 0, 0);
    run(0);
    setup(0, 1, 0, 0, 16'hFFFF, 16'h0, 16'hFFFF, 16'h0, 1, 1, 0);
    run(0);
    // R13: length above the maximum
    setup(20, 1, 0, 0, 16'hFFFF, 16'h0, 16'hFFFF, 16'h0, 0, 0, 5);
    run(2);
    // R2: start while busy is ignored
    setup(10, 1, 0, 0, 16'h03FF, 16'h0, 16'h0155, 16'h0, 0, 0, 0);
    cyc(1, 1);
    cyc(0, 1);
    setup(3, 1, 0, 0, 16'h0001, 16'h0, 16'h0001, 16'h0, 1, 1, 90);
    cyc(1, 0);
    cyc(1, 0);
    start_i = 1'b0;
    drain(2);
    // back-to-back restart after done
    setup(6, 1, 1, 1, 16'h0, 16'h002D, 16'h0, 16'h0036, 0, 1, 60);
    run(2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule